// File: doc/BRIEF.md
# Unaligned Access Bus Splitter

This block sits between a processor core and a banked, byte-addressed memory. The core hands it one load or store at a time: a byte, word or double word at any byte address. The block turns that request into one or more aligned bus cycles. Each bus cycle carries an aligned address, one enable per byte lane, and active-low read and write strobes.

Multi-byte values are little-endian. The byte at the request address is the least significant one, and the higher bytes follow at the next addresses. Each byte travels on the lane given by its address modulo the number of lanes. The block moves bytes between memory lane order and core register order in both directions.

When a request crosses a bus-word boundary, the block issues the bus cycles back to back in ascending address order. It collects the read bytes in a holding register. It signals completion with a single-cycle pulse that carries the assembled read data. The bus width is a parameter and may be 16 or 32 bits. The memory answers within the same cycle; there are no wait states.

Top module: `ubs_splitter`

## Requirements
- R1: After reset, both strobes are high, all byte enables are low, `req_ready` is high and `done` is low.
- R2: The number of bus cycles per request follows these rules. Size code 0 is a byte, 1 is a word, and 2 or 3 is a double word. On a 32-bit bus, a byte takes one cycle. A word takes two cycles when its address mod 4 is 3 and one cycle otherwise. A double word takes one cycle when its address mod 4 is 0 and two cycles otherwise. On a 16-bit bus, a byte takes one cycle. A word takes one cycle at an even address and two at an odd one. A double word takes two cycles at an even address and three at an odd one.
- R3: Every bus address is a multiple of the bus width in bytes. The first cycle uses the request address rounded down to that multiple. Each following cycle of the same request is higher by the bus width in bytes, wrapping modulo 2^ADDR_W.
- R4: In a bus cycle, enable bit l is high exactly when a requested byte with address mod lanes equal to l falls in that cycle's bus word. All enables are low while neither strobe is active.
- R5: For a store, byte i of `req_wdata` (bits 8i+7..8i) is driven on lane (address+i) mod lanes during the cycle that covers address+i. The memory ends up holding exactly the requested bytes, and no others change.
- R6: For a load, the byte at address+i appears in bits 8i+7..8i of `done_rdata`. Bytes above the requested size read as zero.
- R7: A load's bus cycles drive `bus_rd_n` low and `bus_wr_n` high. A store's cycles do the opposite. At all other times both strobes are high, and they are never low together.
- R8: The bus cycles occupy consecutive clock cycles, starting in the cycle after the request is accepted. `done` is high for exactly one cycle, the cycle after the last bus cycle.
- R9: `req_ready` is high only when the block is idle. It is low from the cycle after acceptance through the `done` cycle, so no second request is taken during a split access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 double word |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data in register order |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Assembled load data, valid with `done` |
| bus_addr | output | ADDR_W | Aligned bus address |
| bus_be | output | DATA_W/8 | Byte lane enables, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DATA_W | Store data in lane order |
| bus_rdata | input | DATA_W | Load data from memory in lane order |

## Verification
A request accepted at a clock edge puts its first bus cycle on the bus in the cycle that follows. Cycle k (counting from one) appears k−1 cycles after that, and `done` comes one cycle after the last bus cycle, so n+1 cycles after acceptance for an n-cycle request. The bench records the cycle count at the falling edge after acceptance. It queues each predicted bus cycle and the completion cycle and data, and a monitor compares them at every falling edge, midway between the edges where the registers change. A 32-bit and a 16-bit instance run the same requests side by side. Store effects are checked by comparing each memory model with a reference image once both instances are idle again.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

  localparam int CORE_BYTES = 4;

  // byte count of a size code; code 3 is treated as a double word
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // index of the final bus cycle for a lane offset, byte count and log2(lanes)
  function automatic logic [1:0] last_beat(input logic [1:0] ofs,
                                           input logic [2:0] nbytes,
                                           input int lsh);
    logic [3:0] span;
    span = {2'b00, ofs} + {1'b0, nbytes} - 4'd1;
    return 2'(span >> lsh);
  endfunction

endpackage

// File: rtl/ubs_beat_plan.sv
module ubs_beat_plan #(
  parameter int ADDR_W = 16,
  parameter int LANE_N = 4
) (
  input  logic [ADDR_W-1:0]       base_addr,
  input  logic [1:0]              beat,
  input  logic [2:0]              nbytes,
  output logic [ADDR_W-1:0]       beat_addr,
  output logic [LANE_N-1:0]       lane_sel,
  output logic [LANE_N-1:0][1:0]  lane_off
);
  localparam int LSH = $clog2(LANE_N);

  logic [LSH-1:0] ofs;
  logic [4:0]     first_pos;

  assign ofs       = base_addr[LSH-1:0];
  assign first_pos = {3'b000, beat} << LSH;
  assign beat_addr = {base_addr[ADDR_W-1:LSH], {LSH{1'b0}}} + ADDR_W'(first_pos);

  // per lane: position in the span, relative byte index, membership
  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    logic [4:0] pos;
    logic [4:0] rel;
    assign pos         = first_pos + 5'(l);
    assign rel         = pos - 5'(ofs);
    assign lane_sel[l] = (pos >= 5'(ofs)) && (rel < 5'(nbytes));
    assign lane_off[l] = rel[1:0];
  end

endmodule

// File: rtl/ubs_lane_steer.sv
module ubs_lane_steer #(
  parameter int LANE_N = 4
) (
  input  logic [LANE_N-1:0]       lane_sel,
  input  logic [LANE_N-1:0][1:0]  lane_off,
  input  logic [31:0]             core_wdata,
  input  logic [LANE_N*8-1:0]     bus_rdata,
  input  logic [31:0]             hold,
  output logic [LANE_N*8-1:0]     bus_wdata,
  output logic [31:0]             hold_next
);

  // register order -> lane order
  for (genvar l = 0; l < LANE_N; l++) begin : g_wr
    assign bus_wdata[8*l +: 8] = lane_sel[l] ? core_wdata[8*lane_off[l] +: 8] : 8'h00;
  end

  // lane order -> register order, merged into the holding value
  always_comb begin
    hold_next = hold;
    for (int l = 0; l < LANE_N; l++) begin
      if (lane_sel[l]) hold_next[8*lane_off[l] +: 8] = bus_rdata[8*l +: 8];
    end
  end

endmodule

// File: rtl/ubs_splitter.sv
module ubs_splitter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  input  logic [31:0]          req_wdata,
  output logic                 done,
  output logic [31:0]          done_rdata,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W/8-1:0]  bus_be,
  output logic                 bus_rd_n,
  output logic                 bus_wr_n,
  output logic [DATA_W-1:0]    bus_wdata,
  input  logic [DATA_W-1:0]    bus_rdata
);
  import ubs_pkg::*;

  localparam int LANE_N = DATA_W / 8;
  localparam int LSH    = $clog2(LANE_N);

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_DONE} st_t;

  st_t                      st_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [2:0]               nbytes_q;
  logic                     wr_q;
  logic [31:0]              wdata_q;
  logic [1:0]               beat_q;
  logic [1:0]               last_q;
  logic [31:0]              hold_q;

  logic [LANE_N-1:0]        lane_sel;
  logic [LANE_N-1:0][1:0]   lane_off;
  logic [31:0]              hold_next;
  logic [ADDR_W-1:0]        beat_addr;

  // named internal events
  logic accept, beat_active, beat_final, beat_adv, strobe_on;

  assign req_ready   = (st_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign beat_active = (st_q == ST_BEAT);
  assign beat_final  = beat_active && (beat_q == last_q);
  assign beat_adv    = beat_active && !beat_final;

  ubs_beat_plan #(.ADDR_W(ADDR_W), .LANE_N(LANE_N)) u_plan (
    .base_addr (addr_q),
    .beat      (beat_q),
    .nbytes    (nbytes_q),
    .beat_addr (beat_addr),
    .lane_sel  (lane_sel),
    .lane_off  (lane_off)
  );

  ubs_lane_steer #(.LANE_N(LANE_N)) u_steer (
    .lane_sel   (lane_sel),
    .lane_off   (lane_off),
    .core_wdata (wdata_q),
    .bus_rdata  (bus_rdata),
    .hold       (hold_q),
    .bus_wdata  (bus_wdata),
    .hold_next  (hold_next)
  );

  assign bus_addr   = beat_addr;
  assign bus_be     = beat_active ? lane_sel : '0;
  assign bus_rd_n   = !(beat_active && !wr_q);
  assign bus_wr_n   = !(beat_active && wr_q);
  assign strobe_on  = !bus_rd_n || !bus_wr_n;
  assign done       = (st_q == ST_DONE);
  assign done_rdata = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      nbytes_q <= 3'd1;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      beat_q   <= '0;
      last_q   <= '0;
      hold_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q     <= ST_BEAT;
          addr_q   <= req_addr;
          nbytes_q <= size_bytes(req_size);
          wr_q     <= req_write;
          wdata_q  <= req_wdata;
          beat_q   <= '0;
          last_q   <= last_beat(2'(req_addr[LSH-1:0]), size_bytes(req_size), LSH);
          hold_q   <= '0;
        end
        ST_BEAT: begin
          if (!wr_q) hold_q <= hold_next;
          if (beat_final) st_q <= ST_DONE;
          else            beat_q <= beat_q + 2'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7: the two strobes are never active together
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R3: an active bus address sits on a bus-word boundary
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> (bus_addr[LSH-1:0] == '0));

  // R3: successive cycles of one request climb by one bus word
  p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv |=> (bus_addr == $past(bus_addr) + ADDR_W'(LANE_N)));

  // R4: enables are quiet without a strobe, and some lane takes part with one
  p_be_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_on |-> (bus_be == '0));
  p_be_used_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> (bus_be != '0));

  // R8: completion lasts one cycle and follows a final bus cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_final |=> done);

  // R9: no acceptance while a bus cycle is on the bus
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> !req_ready);

  // R6: a single-byte result has zero upper bytes
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nbytes_q == 3'd1) |-> (done_rdata[31:8] == 24'h0));

endmodule

// File: tb/ubs_splitter_test.sv
module ubs_splitter_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;

  logic        rdy32, dn32, rd32_n, wr32_n;
  logic [31:0] rdat32, wd32, r32;
  logic [7:0]  a32;
  logic [3:0]  be32;

  logic        rdy16, dn16, rd16_n, wr16_n;
  logic [31:0] rdat16;
  logic [15:0] wd16, r16;
  logic [7:0]  a16;
  logic [1:0]  be16;

  ubs_splitter #(.ADDR_W(8), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy32),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .done(dn32), .done_rdata(rdat32),
    .bus_addr(a32), .bus_be(be32), .bus_rd_n(rd32_n), .bus_wr_n(wr32_n),
    .bus_wdata(wd32), .bus_rdata(r32));

  ubs_splitter #(.ADDR_W(8), .DATA_W(16)) uut_w16 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy16),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .done(dn16), .done_rdata(rdat16),
    .bus_addr(a16), .bus_be(be16), .bus_rd_n(rd16_n), .bus_wr_n(wr16_n),
    .bus_wdata(wd16), .bus_rdata(r16));

  logic [7:0] m32 [0:255];
  logic [7:0] m16 [0:255];
  logic [7:0] ref_m [0:255];

  // memory models: same-cycle read, write at the clock edge
  always_comb begin
    r32 = '0;
    if (!rd32_n) for (int l = 0; l < 4; l++) r32[8*l +: 8] = m32[8'(a32 + 8'(l))];
    r16 = '0;
    if (!rd16_n) for (int l = 0; l < 2; l++) r16[8*l +: 8] = m16[8'(a16 + 8'(l))];
  end
  always @(posedge clk) begin
    if (!wr32_n) for (int l = 0; l < 4; l++) if (be32[l]) m32[8'(a32 + 8'(l))] <= wd32[8*l +: 8];
    if (!wr16_n) for (int l = 0; l < 2; l++) if (be16[l]) m16[8'(a16 + 8'(l))] <= wd16[8*l +: 8];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit finished = 0;

  // expected bus cycles {write, be[3:0], addr[7:0]} and completions {write, cycle, data}
  logic [12:0] q32 [$];
  logic [12:0] q16 [$];
  logic [64:0] dq32 [$];
  logic [64:0] dq16 [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push_beat(input int lanes, input logic [12:0] item);
    if (lanes == 4) q32.push_back(item); else q16.push_back(item);
  endtask

  // walk the bytes in address order, opening a new bus word when the base changes
  task automatic plan(input int a0, input int n, input int lanes, input bit wr, output int nb);
    int cur, a, base;
    logic [3:0] be;
    nb = 0; cur = -1; be = '0;
    for (int i = 0; i < n; i++) begin
      a = (a0 + i) % 256;
      base = a - (a % lanes);
      if (base != cur) begin
        if (cur >= 0) begin push_beat(lanes, {wr, be, 8'(cur)}); nb++; end
        cur = base; be = '0;
      end
      be[a % lanes] = 1'b1;
    end
    push_beat(lanes, {wr, be, 8'(cur)});
    nb++;
  endtask

  task automatic mon(input int w, input logic rd_n, input logic wr_n, input logic [3:0] be,
                     input logic [7:0] addr, input logic rdy, input logic dn, input logic [31:0] rdat);
    logic [12:0] e;
    logic [64:0] d;
    string tag;
    tag = (w == 32) ? "w32" : "w16";
    if (!rd_n && !wr_n) chk(0, "R7", {tag, " both strobes"}, 0, 1);
    if (!rd_n || !wr_n) begin
      if ((w == 32 && q32.size() == 0) || (w == 16 && q16.size() == 0)) begin
        chk(0, "R8", {tag, " unexpected bus cycle"}, addr, 0);
      end else begin
        e = (w == 32) ? q32.pop_front() : q16.pop_front();
        chk(addr == e[7:0], "R3", {tag, " bus addr"}, addr, e[7:0]);
        chk(be == e[11:8], "R4", {tag, " byte enables"}, be, e[11:8]);
        chk(wr_n == !e[12] && rd_n == e[12], "R7", {tag, " strobe kind"}, {rd_n, wr_n}, {e[12], !e[12]});
        chk(!rdy, "R9", {tag, " ready in bus cycle"}, rdy, 0);
      end
    end else begin
      chk(be == 4'h0, "R4", {tag, " enables idle"}, be, 0);
    end
    if (dn) begin
      if ((w == 32 && dq32.size() == 0) || (w == 16 && dq16.size() == 0)) begin
        chk(0, "R8", {tag, " unexpected done"}, cyc, 0);
      end else begin
        d = (w == 32) ? dq32.pop_front() : dq16.pop_front();
        chk(cyc == int'(d[63:32]), "R8", {tag, " done cycle"}, cyc, d[63:32]);
        chk(!rdy, "R9", {tag, " ready at done"}, rdy, 0);
        if (!d[64]) chk(rdat == d[31:0], "R6", {tag, " load data"}, rdat, d[31:0]);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      mon(32, rd32_n, wr32_n, be32, a32, rdy32, dn32, rdat32);
      mon(16, rd16_n, wr16_n, {2'b00, be16}, a16, rdy16, dn16, rdat16);
    end
  end

  task automatic wait_idle();
    while (!(rdy32 && rdy16)) @(negedge clk);
  endtask

  task automatic do_req(input int a0, input logic [1:0] size, input bit wr, input logic [31:0] wd);
    int n, nb32, nb16, acc;
    logic [31:0] exp;
    bit same32, same16;
    n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    exp = '0;
    for (int i = 0; i < n; i++) exp |= 32'(ref_m[8'(a0 + i)]) << (8 * i);
    plan(a0, n, 4, wr, nb32);   // R2 cycle counts come out of this walk
    plan(a0, n, 2, wr, nb16);
    if (wr) for (int i = 0; i < n; i++) ref_m[8'(a0 + i)] = wd[8*i +: 8];
    @(negedge clk);
    wait_idle();
    req_valid = 1'b1; req_addr = 8'(a0); req_size = size; req_write = wr; req_wdata = wd;
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
    dq32.push_back({wr, 32'(acc + nb32), exp});
    dq16.push_back({wr, 32'(acc + nb16), exp});
    wait_idle();
    // R2: every predicted bus cycle was consumed
    chk(q32.size() == 0, "R2", "w32 cycle count", q32.size(), 0);
    chk(q16.size() == 0, "R2", "w16 cycle count", q16.size(), 0);
    if (wr) begin
      same32 = 1; same16 = 1;
      for (int i = 0; i < 256; i++) begin
        if (m32[i] !== ref_m[i]) same32 = 0;
        if (m16[i] !== ref_m[i]) same16 = 0;
      end
      chk(same32, "R5", "w32 memory image", same32, 1);
      chk(same16, "R5", "w16 memory image", same16, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R8", "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      m32[i] = 8'(i * 7 + 3); m16[i] = 8'(i * 7 + 3); ref_m[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd32_n && wr32_n && rd16_n && wr16_n, "R1", "strobes high", {rd32_n, wr32_n, rd16_n, wr16_n}, 4'hf);
    chk(be32 == 0 && be16 == 0, "R1", "enables low", {be32, be16}, 0);
    chk(rdy32 && rdy16, "R1", "ready high", {rdy32, rdy16}, 2'b11);
    chk(!dn32 && !dn16, "R1", "done low", {dn32, dn16}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 6; o++) begin
        int a;
        a = 16 * s + 8 + o;
        do_req(a, 2'(s), 1'b1, 32'hA1B2C3D4 ^ 32'(o * 32'h01010101 + s));
        do_req(a, 2'(s), 1'b0, 32'h0);
        do_req(a + 1, 2'(s), 1'b0, 32'h0);
      end
    end
    // wrap across the top of the address space
    do_req(254, 2'd2, 1'b1, 32'h11223344);
    do_req(254, 2'd2, 1'b0, 32'h0);
    do_req(255, 2'd1, 1'b0, 32'h0);
    do_req(255, 2'd0, 1'b0, 32'h0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule